// File: doc/BRIEF.md
# Serial Control Register Port

This block is the slave end of a three-wire control link. A host opens a frame by pulling a low-true load strobe down. It then clocks a command into the port on a slow serial clock. The command carries a direction flag, a register address and a data byte. The port holds eight byte-wide control registers and presents them in parallel to downstream logic. A write is committed to its register only when the strobe is released. A read returns the addressed register on a serial output with a tristate enable, so the host can share one bidirectional wire for command and reply.

All three serial inputs are oversampled by the system clock. They pass through a synchronizer of equal depth, so serial data and serial clock stay aligned to each other, and edges are detected in the system clock domain. Every output, including the parallel register bank, comes straight from a flip-flop.

Frame layout, in order of arrival:
- bit 0: direction flag, where 0 means write and 1 means read.
- bits 1 to 3: the register address, most significant bit first.
- bits 4 to 7: don't-care.
- bits 8 to 15: the data byte, most significant bit first.

Top module: `serial_reg_port`

## Requirements
- R1: After reset, register 0 (mode) holds 0x34, register 1 (channel order) holds 0x21, registers 2 to 7 hold 0x00, and the data enable `ser_dout_en` is low.
- R2: A frame of 16 bits with flag 0 is a write. The bits are sampled on rising serial clock edges while the strobe is low. When the strobe rises, the addressed register, and only that register, takes the data byte. Bits 4 to 7 have no effect.
- R3: No register changes while the strobe is still low, even after all 16 bits have arrived.
- R4: Rising serial clock edges after the 16th within one frame are ignored. The register receives the byte carried in bits 8 to 15.
- R5: If the strobe rises after fewer than 16 rising serial clock edges, the frame is discarded and no register changes.
- R6: In a frame with flag 1, the port presents the addressed register most significant bit first. The first bit appears at the 8th falling serial clock edge, and each following falling edge up to the 15th presents the next bit. A read frame changes no register.
- R7: `ser_dout_en` is high only in a read frame, from the 8th falling serial clock edge until the strobe rises. It is low at all other times, including throughout write frames.
- R8: A read of any address returns the byte most recently committed to that address by a write, or its reset value if no write has been committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, idle low |
| ser_load_n | input | 1 | Frame strobe, low while a frame is active |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial read data toward the shared line |
| ser_dout_en | output | 1 | Tristate enable for `ser_dout`, high while the port drives |
| regs_o | output | 2**ADDR_W*DATA_W | Parallel register contents, register i at bits [i*DATA_W +: DATA_W] |

## Verification
The bench builds the port with its defaults: a 3-bit address, 8-bit registers, 16-bit frames and a two-stage synchronizer. These values make all eight addresses reachable, and they make both non-zero reset bytes visible on the parallel bus and in read-back. The frame length of 16 places the read start at the 8th falling edge and makes overlong frames of up to 20 clocks meaningful. A serial half-period of eight system clocks leaves room for the synchronizer and edge-detect latency, so each sample is taken after the port has settled.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;

  localparam int unsigned MODE_ADDR  = 0;
  localparam int unsigned ORDER_ADDR = 1;

  // mode: correlated sampling (bit 5), wide span (bit 4), three channels (bit 2)
  localparam logic [7:0] MODE_RESET  = 8'h34;
  // channel order: sequence code 01 in bits 6:5, bit 0 set
  localparam logic [7:0] ORDER_RESET = 8'h21;

  function automatic logic [7:0] reg_default(input int unsigned idx);
    if (idx == MODE_ADDR)       return MODE_RESET;
    else if (idx == ORDER_ADDR) return ORDER_RESET;
    else                        return 8'h00;
  endfunction

endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= INIT;
    else     pipe[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= INIT;
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/ser_frame.sv
module ser_frame #(
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned FRAME_BITS = 16,
  localparam int unsigned CNT_W     = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_rise,
  input  logic              load_n,
  input  logic              load_rise,
  input  logic              sdi,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              rw_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);

  localparam logic [CNT_W-1:0] FULL     = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] DSTART   = CNT_W'(FRAME_BITS - DATA_W);

  logic [CNT_W-1:0]  cnt;
  logic              rw;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      rw        <= 1'b0;
      addr      <= '0;
      data      <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (load_n) begin
        cnt <= '0;
        if (load_rise && cnt == FULL && !rw) begin
          wr_en_o   <= 1'b1;
          wr_addr_o <= addr;
          wr_data_o <= data;
        end
      end else if (sclk_rise && cnt != FULL) begin
        cnt <= cnt + 1'b1;
        if (cnt == '0)                 rw   <= sdi;
        else if (cnt <= ADDR_END)      addr <= {addr[ADDR_W-2:0], sdi};
        else if (cnt >= DSTART)        data <= {data[DATA_W-2:0], sdi};
      end
    end
  end

  assign cnt_o  = cnt;
  assign rw_o   = rw;
  assign addr_o = addr;

  AST_WR_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> $past(cnt) == FULL); // R5

  AST_EXTRA_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !load_n && cnt == FULL) |=> $stable(data)); // R4

endmodule

// File: rtl/ser_regfile.sv
module ser_regfile
  import ser_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned NREG  = 1 << ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [NREG*DATA_W-1:0] regs_o
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_V = DATA_W'(reg_default(i));
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                   q <= RST_V;
      else if (wr_en && wr_addr == ADDR_W'(i))   q <= wr_data;
    end
    assign regs_o[i*DATA_W +: DATA_W] = q;
  end

  AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs_o)); // R3

endmodule

// File: rtl/ser_readout.sv
module ser_readout #(
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned FRAME_BITS = 16,
  localparam int unsigned NREG      = 1 << ADDR_W,
  localparam int unsigned CNT_W     = $clog2(FRAME_BITS + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sclk_fall,
  input  logic                   load_n,
  input  logic                   load_rise,
  input  logic [CNT_W-1:0]       cnt,
  input  logic                   rw,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [NREG*DATA_W-1:0] regs,
  output logic                   sdo,
  output logic                   sdo_en
);

  localparam logic [CNT_W-1:0] FULL   = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] DSTART = CNT_W'(FRAME_BITS - DATA_W);

  logic [DATA_W-1:0] sh;
  logic              oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      oe_q <= 1'b0;
    end else if (load_n) begin
      oe_q <= 1'b0;
    end else if (sclk_fall && rw) begin
      if (cnt == DSTART) begin
        sh   <= regs[addr*DATA_W +: DATA_W];
        oe_q <= 1'b1;
      end else if (oe_q && cnt > DSTART && cnt < FULL) begin
        sh <= {sh[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign sdo    = sh[DATA_W-1];
  assign sdo_en = oe_q;

  AST_OE_DROP: assert property (@(posedge clk) disable iff (rst)
    load_rise |=> !oe_q); // R7

  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> rw); // R7

  AST_SHIFT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (oe_q && $past(oe_q) && !$past(sclk_fall)) |-> $stable(sh)); // R6

endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned FRAME_BITS  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              ser_clk,
  input  logic                              ser_load_n,
  input  logic                              ser_din,
  output logic                              ser_dout,
  output logic                              ser_dout_en,
  output logic [(2**ADDR_W)*DATA_W-1:0]     regs_o
);

  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);

  logic [2:0]        sync_q;
  logic              sclk_s, load_s, din_s;
  logic              sclk_d, load_d;
  logic              sclk_rise, sclk_fall, load_rise;
  logic [CNT_W-1:0]  cnt;
  logic              rw;
  logic [ADDR_W-1:0] addr;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  // bit order: {serial clock, strobe, data}; strobe idles high
  ser_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ser_clk, ser_load_n, ser_din}),
    .q   (sync_q)
  );

  assign {sclk_s, load_s, din_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      load_d <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      load_d <= load_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign load_rise = load_s & ~load_d;

  ser_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_BITS(FRAME_BITS)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .sclk_rise (sclk_rise),
    .load_n    (load_s),
    .load_rise (load_rise),
    .sdi       (din_s),
    .cnt_o     (cnt),
    .rw_o      (rw),
    .addr_o    (addr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  ser_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .regs_o  (regs_o)
  );

  ser_readout #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_BITS(FRAME_BITS)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .sclk_fall (sclk_fall),
    .load_n    (load_s),
    .load_rise (load_rise),
    .cnt       (cnt),
    .rw        (rw),
    .addr      (addr),
    .regs      (regs_o),
    .sdo       (ser_dout),
    .sdo_en    (ser_dout_en)
  );

endmodule

// File: tb/serial_reg_port_bench.sv
`timescale 1ns/1ps
module serial_reg_port_bench;

  localparam int NREG = 8;
  localparam int H    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_load_n = 1'b1;
  logic ser_din = 1'b0;
  wire  ser_dout;
  wire  ser_dout_en;
  wire  [NREG*8-1:0] regs;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  logic [7:0] model [NREG];

  always #2.5 clk = ~clk;

  serial_reg_port u_serial_reg_port (
    .clk         (clk),
    .rst         (rst),
    .ser_clk     (ser_clk),
    .ser_load_n  (ser_load_n),
    .ser_din     (ser_din),
    .ser_dout    (ser_dout),
    .ser_dout_en (ser_dout_en),
    .regs_o      (regs)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < NREG; i++)
      check(tag, $sformatf("reg%0d", i), 32'(regs[i*8 +: 8]), 32'(model[i]));
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    end
  endtask

  // f = {flag, addr[2:0], dont-care[3:0], data[7:0]}
  task automatic run_frame(input string tag, input logic [15:0] f, input int nbits);
    logic [2:0] a;
    logic [7:0] exp_rd;
    logic [7:0] got;
    bit oe_ok;
    a      = f[14:12];
    exp_rd = model[a];
    got    = 8'h00;
    oe_ok  = 1'b1;
    ser_load_n = 1'b0;
    wait_clk(H);
    for (int k = 0; k < nbits; k++) begin
      ser_din = (k < 16) ? f[15-k] : 1'($urandom);
      wait_clk(H);
      ser_clk = 1'b1;
      wait_clk(H);
      ser_clk = 1'b0;
      wait_clk(H);
      if (ser_dout_en !== (f[15] && (k + 1) >= 8)) oe_ok = 1'b0;
      if (f[15] && (k + 1) >= 8 && (k + 1) <= 15) got[15-(k+1)] = ser_dout;
    end
    if (nbits >= 16) check_regs("R3");
    ser_load_n = 1'b1;
    wait_clk(H);
    check("R7", "enable after strobe rise", 32'(ser_dout_en), 32'd0);
    if (!f[15] && nbits >= 16) model[a] = f[7:0];
    check_regs(tag);
    if (f[15] && nbits >= 16) check(tag, "read byte R6", 32'(got), 32'(exp_rd));
    check("R7", "enable window", 32'(oe_ok), 32'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    vectors++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    model[0] = 8'h34;
    model[1] = 8'h21;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);

    check_regs("R1");
    check("R1", "enable after reset", 32'(ser_dout_en), 32'd0);

    run_frame("R2", {1'b0, 3'd2, 4'hF, 8'hA5}, 16);
    run_frame("R2", {1'b0, 3'd7, 4'h0, 8'h5A}, 16);
    run_frame("R4", {1'b0, 3'd3, 4'h6, 8'h3C}, 21);
    run_frame("R5", {1'b0, 3'd4, 4'h0, 8'hFF}, 12);
    run_frame("R5", {1'b0, 3'd4, 4'h0, 8'hFF}, 15);
    run_frame("R6", {1'b1, 3'd0, 4'h0, 8'h00}, 16);
    run_frame("R6", {1'b1, 3'd1, 4'h9, 8'hFF}, 16);
    run_frame("R8", {1'b0, 3'd0, 4'h0, 8'h81}, 16);
    run_frame("R8", {1'b1, 3'd0, 4'h0, 8'h00}, 16);
    run_frame("R8", {1'b1, 3'd2, 4'h3, 8'h00}, 18);
    run_frame("R6", {1'b1, 3'd7, 4'h0, 8'h00}, 10);

    for (int n = 0; n < 150; n++) begin
      logic [15:0] f;
      int nb;
      f = 16'($urandom);
      if (($urandom % 4) == 0) nb = 4 + int'($urandom % 12);
      else                     nb = 16 + int'($urandom % 5);
      run_frame("R8", f, nb);
    end

    report();
    $finish;
  end

endmodule